// File: doc/BRIEF.md
# Flash ROM Bus Interface Controller

This block sits between a 32-bit host bus and an external flash or ROM device that occupies a 16 MiB window, so the device address is 24 bits. The host makes an access by raising a request with a direction, an address and write data. The block then drives the device chip select, output enable and write enable in a fixed order. When the access is finished it returns a one-cycle ready pulse, and on reads it returns the read word.

A control register sets the device data width to 8, 16 or 32 bits. It also holds three separate 4-bit wait counts, each in clock cycles:

- the strobe length of an ordinary access;
- the strobe length of a read that follows on to the next sequential device address;
- the turnaround gap after the strobe.

A count of zero means sixteen cycles. A separate 2-bit lane register lets narrow writes be issued at a word-aligned host address. The device address then takes its two low bits from the lane register instead of from the bus.

Top module: `flash_bus_ctrl`

## Requirements
- R1: Control bits 15:14 select the device width: 2'b01 gives 8 bits, 2'b10 gives 16 bits and 2'b11 gives 32 bits. With 2'b00, a request returns ready and err_o together one cycle after it is accepted, and no strobe or chip select is asserted. err_o is low on every other completion.
- R2: Control bits 19:16 set the ordinary strobe length: oe/we stays low for that many consecutive cycles, and a value of 0 gives 16 cycles. The device address stays stable while chip select is low.
- R3: Control bits 27:24 set the turnaround length T, with 0 giving 16. For an access with strobe length N, ready_o goes high N+T+2 cycles after the cycle in which the request is accepted. That is one select-only setup cycle, N strobe cycles, T turnaround cycles with chip select high, and then ready.
- R4: Control bits 23:20 set the follow-on strobe length, with 0 giving 16. It replaces the ordinary length for a read whose device address is exactly one beat (1, 2 or 4 bytes for width 8, 16 or 32) above that of the previous accepted access, provided that the previous access was a read and no control write has happened at or after its acceptance.
- R5: In 8-bit and 16-bit modes, the device address of a write is host address bits 23:2 joined with the 2-bit lane register. Host address bits 1:0 are ignored.
- R6: In 32-bit mode, a write uses the host address unchanged and the lane register has no effect.
- R7: A read returns the device data masked to the low 1, 2 or 4 bytes for 8, 16 or 32-bit width, with the upper bytes zero. A write drives the host data masked in the same way.
- R8: ready_o is high for exactly one cycle per access.
- R9: The control register value used by an access is the one held when the access is accepted. A control write during an access applies only to later accesses.
- R10: Reset releases all device strobes, clears ready and sets 32-bit width with all three counts at 16, so the first read takes 34 cycles.
- R11: Chip select is asserted one cycle before oe or we. oe and we are never low together. The data drivers are enabled only for writes, and only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write value |
| lane_we_i | input | 1 | Lane register write strobe |
| lane_i | input | 2 | Lane value for narrow writes |
| req_i | input | 1 | Access request, held until ready |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Host byte address in the window |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data, valid with ready |
| ready_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Undefined-width completion |
| fl_addr_o | output | 24 | Device address |
| fl_cs_n_o | output | 1 | Device chip select, active low |
| fl_oe_n_o | output | 1 | Device output enable, active low |
| fl_we_n_o | output | 1 | Device write enable, active low |
| fl_dq_o | output | 32 | Device write data |
| fl_dq_oe_o | output | 1 | Device data driver enable |
| fl_dq_i | input | 32 | Device read data |

## Verification
A control register write can land in the same cycle as an access that is already running. The bench starts a read with a short strobe count and writes a much longer count three cycles later, while the strobe is in progress. The read's ready latency must still match the old count, and the next read must match the new one. A control write also resets the follow-on-read tracking. The bench therefore repeats a sequential read pair with a rewrite of the same control value between the two reads, and requires the ordinary strobe length on the second read.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [1:0] {
    DW_RSVD = 2'b00,
    DW_8    = 2'b01,
    DW_16   = 2'b10,
    DW_32   = 2'b11
  } dev_width_e;

  localparam int CTRL_W    = 32;
  localparam int WAIT_W    = 4;
  localparam int WIDTH_LSB = 14;
  localparam int ACC_LSB   = 16;
  localparam int BST_LSB   = 20;
  localparam int TRN_LSB   = 24;

  typedef struct packed {
    dev_width_e          width;
    logic [WAIT_W-1:0]   acc;
    logic [WAIT_W-1:0]   bst;
    logic [WAIT_W-1:0]   trn;
  } bus_cfg_t;

  localparam bus_cfg_t CFG_RESET = '{width: DW_32, acc: '0, bst: '0, trn: '0};

  function automatic int unsigned beat_bytes(dev_width_e w);
    case (w)
      DW_8:    return 1;
      DW_16:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_bus_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              lane_we_i,
  input  logic [LANE_W-1:0] lane_i,
  output bus_cfg_t          cfg_o,
  output logic [LANE_W-1:0] lane_o
);

  bus_cfg_t          cfg_q;
  logic [LANE_W-1:0] lane_q;

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl_wdata_i[CTRL_W-1:TRN_LSB+WAIT_W],
                              ctrl_wdata_i[WIDTH_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RESET;
      lane_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        cfg_q.width <= dev_width_e'(ctrl_wdata_i[WIDTH_LSB +: 2]);
        cfg_q.acc   <= ctrl_wdata_i[ACC_LSB +: WAIT_W];
        cfg_q.bst   <= ctrl_wdata_i[BST_LSB +: WAIT_W];
        cfg_q.trn   <= ctrl_wdata_i[TRN_LSB +: WAIT_W];
      end
      if (lane_we_i) lane_q <= lane_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign lane_o = lane_q;

endmodule

// File: rtl/flash_addr_gen.sv
module flash_addr_gen
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 2
) (
  input  dev_width_e        width_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              prev_ok_i,
  input  logic [ADDR_W-1:0] prev_addr_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              follow_o
);

  logic              narrow;
  logic [ADDR_W-1:0] step;

  assign narrow     = (width_i == DW_8) || (width_i == DW_16);
  assign dev_addr_o = (wr_i && narrow) ? {addr_i[ADDR_W-1:LANE_W], lane_i} : addr_i;
  assign step       = ADDR_W'(beat_bytes(width_i));
  assign follow_o   = !wr_i && prev_ok_i && (dev_addr_o == prev_addr_i + step);

endmodule

// File: rtl/flash_lane_mask.sv
module flash_lane_mask
  import flash_bus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dev_width_e        width_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int NBYTES = DATA_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign data_o[g*8 +: 8] = (32'(g) < beat_bytes(width_i)) ? data_i[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/flash_strobe_seq.sv
module flash_strobe_seq #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bad_i,
  input  logic              wr_i,
  input  logic [WAIT_W-1:0] strb_cnt_i,
  input  logic [WAIT_W-1:0] turn_cnt_i,
  output logic              idle_o,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              dq_oe_o,
  output logic              capture_o,
  output logic              ready_o,
  output logic              err_o
);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_TURN, ST_DONE} st_e;

  st_e               st_q;
  logic [WAIT_W-1:0] cnt_q, strb_q, turn_q;
  logic              wr_q, err_q;

  // count of 0 wraps to all-ones, giving 2**WAIT_W cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      strb_q <= '0;
      turn_q <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          err_q  <= bad_i;
          wr_q   <= wr_i;
          strb_q <= strb_cnt_i;
          turn_q <= turn_cnt_i;
          st_q   <= bad_i ? ST_DONE : ST_SETUP;
        end
        ST_SETUP: begin
          cnt_q <= strb_q - WAIT_W'(1);
          st_q  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            cnt_q <= turn_q - WAIT_W'(1);
            st_q  <= ST_TURN;
          end else begin
            cnt_q <= cnt_q - WAIT_W'(1);
          end
        end
        ST_TURN: begin
          if (cnt_q == '0) st_q <= ST_DONE;
          else             cnt_q <= cnt_q - WAIT_W'(1);
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign cs_n_o    = !((st_q == ST_SETUP) || (st_q == ST_STROBE));
  assign oe_n_o    = !((st_q == ST_STROBE) && !wr_q);
  assign we_n_o    = !((st_q == ST_STROBE) && wr_q);
  assign dq_oe_o   = wr_q && ((st_q == ST_SETUP) || (st_q == ST_STROBE));
  assign capture_o = (st_q == ST_STROBE) && (cnt_q == '0) && !wr_q;
  assign ready_o   = (st_q == ST_DONE);
  assign err_o     = (st_q == ST_DONE) && err_q;

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              lane_we_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic              fl_cs_n_o,
  output logic              fl_oe_n_o,
  output logic              fl_we_n_o,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [DATA_W-1:0] fl_dq_i
);

  bus_cfg_t          cfg;
  logic [LANE_W-1:0] lane;
  logic              idle, start, bad, follow, capture;
  logic [ADDR_W-1:0] dev_addr;
  logic [DATA_W-1:0] wdata_m, rdata_m;
  logic [WAIT_W-1:0] strb_sel;

  logic [ADDR_W-1:0] addr_q, prev_addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  dev_width_e        width_q;
  logic              prev_ok_q;

  flash_cfg_regs #(.LANE_W(LANE_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .lane_we_i    (lane_we_i),
    .lane_i       (lane_i),
    .cfg_o        (cfg),
    .lane_o       (lane)
  );

  flash_addr_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
    .width_i     (cfg.width),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .lane_i      (lane),
    .prev_ok_i   (prev_ok_q),
    .prev_addr_i (prev_addr_q),
    .dev_addr_o  (dev_addr),
    .follow_o    (follow)
  );

  flash_lane_mask #(.DATA_W(DATA_W)) u_wmask (
    .width_i (cfg.width),
    .data_i  (wdata_i),
    .data_o  (wdata_m)
  );

  flash_lane_mask #(.DATA_W(DATA_W)) u_rmask (
    .width_i (width_q),
    .data_i  (fl_dq_i),
    .data_o  (rdata_m)
  );

  assign bad      = (cfg.width == DW_RSVD);
  assign start    = req_i && idle;
  assign strb_sel = follow ? cfg.bst : cfg.acc;

  flash_strobe_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .bad_i      (bad),
    .wr_i       (wr_i),
    .strb_cnt_i (strb_sel),
    .turn_cnt_i (cfg.trn),
    .idle_o     (idle),
    .cs_n_o     (fl_cs_n_o),
    .oe_n_o     (fl_oe_n_o),
    .we_n_o     (fl_we_n_o),
    .dq_oe_o    (fl_dq_oe_o),
    .capture_o  (capture),
    .ready_o    (ready_o),
    .err_o      (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      width_q     <= DW_32;
      prev_addr_q <= '0;
      prev_ok_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (start) begin
        if (!bad) begin
          addr_q      <= dev_addr;
          wdata_q     <= wdata_m;
          width_q     <= cfg.width;
          prev_addr_q <= dev_addr;
        end
        prev_ok_q <= !bad && !wr_i;
      end
      // any control write breaks the follow-on chain
      if (ctrl_we_i) prev_ok_q <= 1'b0;
      if (capture) rdata_q <= rdata_m;
    end
  end

  assign fl_addr_o = addr_q;
  assign fl_dq_o   = wdata_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              err_o,
  input logic              fl_cs_n_o,
  input logic              fl_oe_n_o,
  input logic              fl_we_n_o,
  input logic              fl_dq_oe_o,
  input logic [ADDR_W-1:0] fl_addr_o
);

  logic       strobe;
  logic [5:0] run_q;

  assign strobe = !fl_oe_n_o || !fl_we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (strobe) run_q <= run_q + 6'd1;
    else             run_q <= '0;
  end

  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_oe_n_o && !fl_we_n_o));

  a_r11_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> !fl_cs_n_o);

  a_r11_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_cs_n_o) |-> (fl_oe_n_o && fl_we_n_o));

  a_r11_dq_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_o |-> (fl_oe_n_o && !fl_cs_n_o));

  a_r8_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r1_err_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && fl_cs_n_o));

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_cs_n_o && !$past(fl_cs_n_o)) |-> $stable(fl_addr_o));

  a_r2_strobe_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 6'd16);

  a_r3_turn_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (fl_cs_n_o && $past(fl_cs_n_o)));

endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .fl_cs_n_o  (fl_cs_n_o),
  .fl_oe_n_o  (fl_oe_n_o),
  .fl_we_n_o  (fl_we_n_o),
  .fl_dq_oe_o (fl_dq_oe_o),
  .fl_addr_o  (fl_addr_o)
);

// File: tb/tb_flash_bus_ctrl.sv
module tb_flash_bus_ctrl;

  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [31:0]   ctrl_wd = '0;
  logic          lane_we = 1'b0;
  logic [1:0]    lane = '0;
  logic          req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, fl_dq_o, fl_dq_i;
  logic          ready, err, cs_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] fl_addr;

  always #2 clk = ~clk;

  assign fl_dq_i = {fl_addr[7:0] ^ 8'hC3, fl_addr};

  flash_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .lane_we_i(lane_we), .lane_i(lane), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .err_o(err),
    .fl_addr_o(fl_addr), .fl_cs_n_o(cs_n), .fl_oe_n_o(oe_n), .fl_we_n_o(we_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe_o(dq_oe), .fl_dq_i(fl_dq_i)
  );

  int checks = 0;
  int errors = 0;

  int            run = 0, last_pulse = 0, pulses = 0;
  logic [AW-1:0] wr_addr_seen;
  logic [DW-1:0] wr_data_seen;

  always @(negedge clk) begin
    if (!oe_n || !we_n) begin
      run = run + 1;
      if (!we_n) begin
        wr_addr_seen = fl_addr;
        wr_data_seen = fl_dq_o;
      end
    end else if (run > 0) begin
      last_pulse = run;
      pulses = pulses + 1;
      run = 0;
    end
  end

  function automatic logic [31:0] cw(int w, int a, int b, int t);
    return (32'(t & 15) << 24) | (32'(b & 15) << 20) | (32'(a & 15) << 16) | (32'(w & 3) << 14);
  endfunction

  function automatic int dec(int c);
    return (c == 0) ? 16 : c;
  endfunction

  function automatic logic [31:0] msk(int w);
    return (w == 1) ? 32'h0000_00FF : (w == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] pat(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hC3, a};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic set_lane(logic [1:0] v);
    @(negedge clk); lane_we = 1'b1; lane = v;
    @(negedge clk); lane_we = 1'b0;
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                     output int lat, output logic [31:0] rd, output logic er);
    @(negedge clk); req = 1'b1; wr = w; addr = a; wdata = d; lat = 0;
    do begin
      @(negedge clk); lat++;
    end while (!ready && lat < 200);
    rd = rdata; er = err; req = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R8 ready one cycle", 32'(ready), 32'd0);
  endtask

  int          lat, p0;
  logic [31:0] rd;
  logic        er;

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset cs_n", 32'(cs_n), 32'd1);
    chk("R10 reset oe_n", 32'(oe_n), 32'd1);
    chk("R10 reset we_n", 32'(we_n), 32'd1);
    chk("R10 reset ready", 32'(ready), 32'd0);
    rst_n = 1'b1;

    acc(1'b0, 24'h000040, '0, lat, rd, er);
    chk("R10 default latency", 32'(lat), 32'd34);
    chk("R10 default strobe", 32'(last_pulse), 32'd16);
    chk("R10 default read data", rd, pat(24'h000040));

    // R2 R3 sweep of access and turnaround counts, 32-bit reads
    for (int a = 0; a < 16; a++) begin
      for (int t = 0; t < 16; t++) begin
        logic [AW-1:0] ad;
        ad = AW'(24'h010000 + (a * 16 + t) * 16);
        set_ctrl(cw(3, a, 0, t));
        acc(1'b0, ad, '0, lat, rd, er);
        chk("R3 ready latency", 32'(lat), 32'(dec(a) + dec(t) + 2));
        chk("R2 strobe length", 32'(last_pulse), 32'(dec(a)));
        chk("R7 32-bit read data", rd, pat(ad));
      end
    end

    // R4 follow-on reads
    set_ctrl(cw(3, 5, 2, 1));
    acc(1'b0, 24'h000100, '0, lat, rd, er);
    chk("R4 first read latency", 32'(lat), 32'd8);
    chk("R1 err low on good width", 32'(er), 32'd0);
    acc(1'b0, 24'h000104, '0, lat, rd, er);
    chk("R4 sequential read latency", 32'(lat), 32'd5);
    chk("R4 sequential strobe", 32'(last_pulse), 32'd2);
    acc(1'b0, 24'h00010C, '0, lat, rd, er);
    chk("R4 gap read latency", 32'(lat), 32'd8);
    acc(1'b1, 24'h000110, 32'h1, lat, rd, er);
    chk("R4 write latency", 32'(lat), 32'd8);
    acc(1'b0, 24'h000114, '0, lat, rd, er);
    chk("R4 read after write latency", 32'(lat), 32'd8);
    set_ctrl(cw(1, 4, 3, 2));
    acc(1'b0, 24'h000200, '0, lat, rd, er);
    chk("R4 8-bit first read latency", 32'(lat), 32'd8);
    acc(1'b0, 24'h000201, '0, lat, rd, er);
    chk("R4 8-bit sequential latency", 32'(lat), 32'd7);
    chk("R7 8-bit read masked", rd, pat(24'h000201) & msk(1));
    acc(1'b0, 24'h000300, '0, lat, rd, er);
    set_ctrl(cw(1, 4, 3, 2));
    acc(1'b0, 24'h000301, '0, lat, rd, er);
    chk("R4 control write breaks chain", 32'(lat), 32'd8);

    // R5 narrow writes take the lane register
    for (int w = 1; w <= 2; w++) begin
      for (int l = 0; l < 4; l++) begin
        logic [AW-1:0] ad;
        logic [31:0]   d;
        ad = AW'(24'h05ABC3 + l * 8);
        d  = 32'hA1B2C3D4 ^ 32'(l * 16 + w);
        set_ctrl(cw(w, 2, 0, 1));
        set_lane(2'(l));
        wr_addr_seen = 'x;
        acc(1'b1, ad, d, lat, rd, er);
        chk("R5 narrow write address", 32'(wr_addr_seen), 32'({ad[AW-1:2], 2'(l)}));
        chk("R7 narrow write data", wr_data_seen, d & msk(w));
      end
    end

    // R6 32-bit write ignores lane
    set_ctrl(cw(3, 2, 0, 1));
    set_lane(2'd2);
    wr_addr_seen = 'x;
    acc(1'b1, 24'h00ABC4, 32'hDEADBEEF, lat, rd, er);
    chk("R6 32-bit write address", 32'(wr_addr_seen), 32'h0000ABC4);
    chk("R6 32-bit write data", wr_data_seen, 32'hDEADBEEF);

    // R7 narrow reads zero-extended
    set_ctrl(cw(2, 3, 0, 1));
    acc(1'b0, 24'h000022, '0, lat, rd, er);
    chk("R7 16-bit read masked", rd, pat(24'h000022) & msk(2));
    set_ctrl(cw(1, 3, 0, 1));
    acc(1'b0, 24'h000013, '0, lat, rd, er);
    chk("R7 8-bit read masked", rd, pat(24'h000013) & msk(1));

    // R9 control write during access
    set_ctrl(cw(3, 3, 0, 2));
    fork
      acc(1'b0, 24'h000400, '0, lat, rd, er);
      begin
        repeat (3) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wd = cw(3, 9, 0, 2);
        @(negedge clk); ctrl_we = 1'b0;
      end
    join
    chk("R9 in-flight latency uses old count", 32'(lat), 32'd7);
    acc(1'b0, 24'h000500, '0, lat, rd, er);
    chk("R9 next access uses new count", 32'(lat), 32'd13);

    // R1 undefined width
    set_ctrl(cw(0, 2, 0, 1));
    p0 = pulses;
    acc(1'b0, 24'h000600, '0, lat, rd, er);
    chk("R1 undefined width latency", 32'(lat), 32'd1);
    chk("R1 undefined width err", 32'(er), 32'd1);
    chk("R1 undefined width no strobe", 32'(pulses), 32'(p0));
    set_ctrl(cw(3, 2, 0, 1));
    acc(1'b0, 24'h000700, '0, lat, rd, er);
    chk("R1 recovery latency", 32'(lat), 32'd5);
    chk("R1 recovery err low", 32'(er), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule